// File: doc/BRIEF.md
# Serial Memory Sleep Controller

This block governs the low-power state of a serial memory slave. The command decoder strobes `sleep_op_i` when a complete sleep opcode has been shifted in. The controller then watches the rest of the transaction. If chip select is released with no further serial clock edge, the slave enters sleep. If any serial clock rising edge arrives first, the request is dropped.

While asleep, the controller holds the serial output enable low and ignores serial clock activity. A falling chip select starts a recovery window. The window is a fixed number of system-clock cycles, and its default corresponds to 400 µs at 250 MHz. When the window closes, `ready_o` returns high and `wake_o` pulses for one cycle so that the write-enable latch is cleared. Chip select may be raised during the window. A second fall of chip select inside the window is a protocol violation: it is flagged on `proto_err_o` and has no other effect.

Chip select and the serial clock are both brought into the system-clock domain through two-flop synchronisers before any edge is detected.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, `ready_o`=1, `sleep_o`=0, `wake_o`=0, `proto_err_o`=0, and `so_oe_o` follows `so_oe_i`.
- R2: A `sleep_op_i` strobe while chip select is low, followed by a chip-select rise with no serial clock rising edge in between, sets `sleep_o`=1 and `ready_o`=0.
- R3: A serial clock rising edge after the strobe and before the chip-select rise cancels the request, so `sleep_o` stays 0.
- R4: A strobe and a synchronised serial clock rising edge seen in the same system-clock cycle keep the request armed, because that edge belongs to the opcode itself.
- R5: A chip-select rise with no preceding strobe never enters sleep.
- R6: While `sleep_o`=1, serial clock activity and `sleep_op_i` have no effect, and `so_oe_o`=0 whenever `ready_o`=0.
- R7: A chip-select fall during sleep clears `sleep_o` and starts recovery. `ready_o` returns to 1 after exactly REC_CYCLES system-clock cycles spent with both `sleep_o` and `ready_o` low.
- R8: Raising chip select during recovery changes neither the recovery length nor its outcome.
- R9: A second chip-select fall during recovery pulses `proto_err_o` for one cycle and does not restart or lengthen the window.
- R10: `wake_o` is high for exactly the one cycle in which `ready_o` rises after recovery, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the synchronisers and the recovery timer |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sleep_op_i | input | 1 | One-cycle strobe: a sleep opcode has been recognised |
| so_oe_i | input | 1 | Serial output enable requested by the read path |
| sleep_o | output | 1 | The slave is in the low-power state |
| ready_o | output | 1 | The slave may accept commands |
| wake_o | output | 1 | One-cycle pulse at the end of recovery; clears the write-enable latch |
| proto_err_o | output | 1 | One-cycle pulse: chip select fell again during recovery |
| so_oe_o | output | 1 | Gated serial output enable |

## Verification
The opcode strobe and the synchronised serial clock edge can land in the same system-clock cycle: the opcode's last clock edge and the decoder's strobe arrive together. The bench provokes this coincidence by timing the strobe against the two-stage synchroniser delay, so that both reach the arm logic on the same edge. The request must then stay armed, and the scoreboard must see a sleep entry at the next chip-select rise. A chip-select fall inside the recovery window is also driven, and judged by the order of queued events (error, then wake) and by the measured window length.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ASLEEP  = 2'd1,
    ST_RECOVER = 2'd2
  } sleep_state_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sleep_arm.sv
module sleep_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic set_i,
  input  logic cancel_i,
  input  logic clear_i,
  output logic armed_o
);
  logic armed_q;

  // a strobe outranks a same-cycle clock edge: that edge ended the opcode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 armed_q <= 1'b0;
    else if (clear_i || !enable_i) armed_q <= 1'b0;
    else if (set_i)              armed_q <= 1'b1;
    else if (cancel_i)           armed_q <= 1'b0;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/sleep_rec_timer.sv
module sleep_rec_timer #(
  parameter int unsigned REC_CYCLES = 100000,
  localparam int unsigned CNT_W = (REC_CYCLES < 2) ? 1 : $clog2(REC_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(REC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned REC_US     = 400,
  parameter int unsigned REC_CYCLES = CLK_MHZ * REC_US
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sleep_op_i,
  input  logic so_oe_i,
  output logic sleep_o,
  output logic ready_o,
  output logic wake_o,
  output logic proto_err_o,
  output logic so_oe_o
);
  logic [1:0] pin_s;
  logic cs_s, sck_s, cs_q, sck_q;
  logic cs_rise, cs_fall, sck_rise;
  logic armed, rec_done, rec_start;
  logic wake_q, err_q;
  sleep_state_e state_q, state_d;

  sleep_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni}),
    .q_o   (pin_s)
  );
  assign cs_s  = pin_s[0];
  assign sck_s = pin_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign cs_rise  = cs_s & ~cs_q;
  assign cs_fall  = ~cs_s & cs_q;
  assign sck_rise = sck_s & ~sck_q;

  sleep_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(state_q == ST_AWAKE && !cs_s),
    .set_i   (sleep_op_i),
    .cancel_i(sck_rise),
    .clear_i (cs_rise),
    .armed_o (armed)
  );

  assign rec_start = (state_q == ST_ASLEEP) && cs_fall;

  sleep_rec_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rec_start),
    .run_i  (state_q == ST_RECOVER),
    .done_o (rec_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE:   if (armed && cs_rise && !sck_rise) state_d = ST_ASLEEP;
      ST_ASLEEP:  if (cs_fall) state_d = ST_RECOVER;
      ST_RECOVER: if (rec_done) state_d = ST_AWAKE;
      default:    state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      wake_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= (state_q == ST_RECOVER) && rec_done;
      // fall inside the window: flag it, do not restart
      err_q   <= (state_q == ST_RECOVER) && cs_fall && !rec_done;
    end
  end

  assign sleep_o     = (state_q == ST_ASLEEP);
  assign ready_o     = (state_q == ST_AWAKE);
  assign wake_o      = wake_q;
  assign proto_err_o = err_q;
  assign so_oe_o     = so_oe_i & ready_o;
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
  parameter int unsigned REC_CYCLES = 100000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_o,
  input logic ready_o,
  input logic wake_o,
  input logic proto_err_o,
  input logic so_oe_o
);
  logic [31:0] rec_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rec_len_q <= '0;
    else if (sleep_o || ready_o) rec_len_q <= '0;
    else                         rec_len_q <= rec_len_q + 1'b1;
  end

  assert_entry_from_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(ready_o));

  assert_oe_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !so_oe_o);

  assert_no_direct_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(!sleep_o && !ready_o));

  assert_rec_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (rec_len_q == REC_CYCLES));

  assert_err_in_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> (!ready_o && !sleep_o));

  assert_wake_on_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $rose(ready_o));

  assert_rise_has_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> wake_o);
endmodule

bind sleep_ctrl sleep_ctrl_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sleep_o    (sleep_o),
  .ready_o    (ready_o),
  .wake_o     (wake_o),
  .proto_err_o(proto_err_o),
  .so_oe_o    (so_oe_o)
);

// File: tb/sleep_ctrl_bench.sv
module sleep_ctrl_bench;
  localparam int unsigned REC = 20;
  localparam int EV_SLEEP = 0, EV_WAKE = 1, EV_ERR = 2;

  typedef struct {
    int    kind;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sleep_op = 1'b0, so_oe = 1'b1;
  logic sleep, ready, wake, perr, so_oe_g;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int rec_len = 0;
  logic prev_sleep = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sleep_ctrl #(.REC_CYCLES(REC)) u_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck),
    .sleep_op_i(sleep_op), .so_oe_i(so_oe),
    .sleep_o(sleep), .ready_o(ready), .wake_o(wake),
    .proto_err_o(perr), .so_oe_o(so_oe_g)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input string tag);
    exp_t e;
    e.kind = kind;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck = 1'b1; cyc(4);
    sck = 1'b0; cyc(4);
  endtask

  task automatic strobe();
    sleep_op = 1'b1; cyc(1);
    sleep_op = 1'b0;
  endtask

  // opcode clocks, strobe, release CS
  task automatic enter_sleep(input string tag);
    cs_n = 1'b0; cyc(5);
    for (int i = 0; i < 8; i++) sck_pulse();
    strobe();
    cyc(3);
    push(EV_SLEEP, tag);
    cs_n = 1'b1; cyc(6);
  endtask

  // monitor: pop and compare as events appear
  task automatic observe(input int kind, input int len);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event: actual kind %0d expected none", kind);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != kind) begin
      fails++;
      $display("FAIL %s: actual kind %0d expected kind %0d", e.tag, kind, e.kind);
    end else if (kind == EV_WAKE && len != REC) begin
      fails++;
      $display("FAIL %s: actual window %0d expected %0d", e.tag, len, REC);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sleep && !prev_sleep) begin
        observe(EV_SLEEP, 0);
        rec_len = 0;
      end
      if (!sleep && !ready) rec_len++;
      if (wake) observe(EV_WAKE, rec_len);
      if (perr) observe(EV_ERR, 0);
      prev_sleep = sleep;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cyc(100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 ready", ready, 1);
    chk("R1 sleep", sleep, 0);
    chk("R1 wake/err", wake | perr, 0);
    chk("R1 so_oe", so_oe_g, 1);

    // basic entry
    enter_sleep("R2 entry");
    chk("R2 sleep", sleep, 1);
    chk("R2 ready", ready, 0);
    chk("R6 so_oe gated", so_oe_g, 0);
    // activity while asleep (CS high)
    for (int i = 0; i < 4; i++) sck_pulse();
    strobe();
    cyc(6);
    chk("R6 still asleep", sleep, 1);
    chk("R6 not ready", ready, 0);
    // wake with CS rising mid-window (R8)
    push(EV_WAKE, "R7 R10 wake");
    cs_n = 1'b0; cyc(8);
    chk("R7 recovering", {31'd0, sleep} + {31'd0, ready}, 0);
    chk("R6 so_oe in recovery", so_oe_g, 0);
    cs_n = 1'b1; cyc(REC + 10);
    chk("R8 ready after window", ready, 1);
    chk("R6 so_oe restored", so_oe_g, 1);

    // cancel by extra SCK
    cs_n = 1'b0; cyc(5);
    for (int i = 0; i < 8; i++) sck_pulse();
    strobe();
    cyc(2);
    sck_pulse();
    cs_n = 1'b1; cyc(10);
    chk("R3 cancelled", sleep, 0);
    chk("R3 ready", ready, 1);

    // plain command, no strobe
    cs_n = 1'b0; cyc(5);
    for (int i = 0; i < 8; i++) sck_pulse();
    cs_n = 1'b1; cyc(10);
    chk("R5 no sleep", sleep, 0);

    // strobe coincides with synchronised SCK rise
    cs_n = 1'b0; cyc(5);
    sck = 1'b1; cyc(2);
    strobe();
    cyc(2);
    sck = 1'b0; cyc(4);
    push(EV_SLEEP, "R4 coincident");
    cs_n = 1'b1; cyc(8);
    chk("R4 asleep", sleep, 1);
    push(EV_WAKE, "R4 wake");
    cs_n = 1'b0; cyc(REC + 10);
    cs_n = 1'b1; cyc(6);

    // second fall inside window
    enter_sleep("R9 entry");
    push(EV_ERR, "R9 error");
    push(EV_WAKE, "R9 window unchanged");
    cs_n = 1'b0; cyc(4);
    cs_n = 1'b1; cyc(3);
    cs_n = 1'b0; cyc(3);
    chk("R9 not ready", ready, 0);
    cyc(REC + 10);
    chk("R9 ready", ready, 1);
    cs_n = 1'b1; cyc(10);

    chk("R10 queue drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule